// File: doc/BRIEF.md
# Periodic Temperature Conversion Scheduler with Limit Alarms

This block paces temperature conversions for a two-channel sensor (one local, one remote) and checks each returned pair of readings against programmable limits. A rate code picks the spacing between conversions as a power-of-two multiple of a base tick. Each conversion starts with a one-cycle request to an external converter. When the converter returns its done strobe, the block compares both signed 8-bit readings against a high and a low limit per channel. Any limit that is crossed sets a sticky alarm bit.

Software reaches the block through a flat 8-entry register space with separate write and read strobes. The space holds a control register that carries an alert-mask flag and a standby flag, the rate code, four limit registers, a status register that clears when read, and a trigger address. In standby the block starts no conversions of its own. A write to the trigger address then runs exactly one conversion-and-compare pass. An active-low alert pin reports any pending alarm unless the mask flag is set.

Top module: `conv_sched`

## Requirements
- R1: After reset the control register reads 00h (running, alert unmasked), the rate register reads 00h, status reads 0, and alert_n is high.
- R2: Control register (address 0): bit 7 is the alert mask (1 = masked) and bit 6 is standby (1 = standby). Bits 5..0 always read 0.
- R3: In run mode, consecutive conversion requests are spaced TICK_CYC × 2^(7−code) cycles apart, where code is the 3-bit rate value. Code 7 gives one base tick and code 0 gives 128.
- R4: Rate register (address 1): a written value above 07h is stored as 07h. Bits 7..3 always read 0.
- R5: Address map: 2 local high, 3 local low, 4 remote high, 5 remote low, 6 status, 7 trigger. Each limit register reads back the value last written. Reset values are 7Fh for the high limits and 80h for the low limits.
- R6: Readings and limits are two's-complement. A high alarm is set only when the reading is strictly greater than its high limit.
- R7: A low alarm is set only when the reading is strictly less than its low limit.
- R8: In standby, a write to address 7 raises conv_req for exactly one cycle, in the cycle after the write. No further request follows. The written data is not kept, and address 7 reads 00h.
- R9: In run mode, a write to address 7 has no effect on the request schedule.
- R10: Clearing the standby bit raises conv_req in the second cycle after the write, without waiting for a period.
- R11: Status bits (0 local high, 1 local low, 2 remote high, 3 remote low) stay set until address 6 is read. Such a read clears them, except that a bit set by a comparison in that same cycle survives.
- R12: alert_n is low exactly while any status bit is set and the mask bit is 0.
- R13: In standby, conv_req stays low unless a trigger write occurs.
- R14: conv_req is a single-cycle pulse. No new request is issued until conv_done has returned for the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (clears status at address 6) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| conv_req | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | Converter result valid |
| local_temp | input | 8 | Local reading, signed |
| remote_temp | input | 8 | Remote reading, signed |
| status | output | 4 | Sticky alarm bits |
| alert_n | output | 1 | Active-low alarm output |

## Verification
A read of the status register can land in the same cycle as a returning conversion that sets a new alarm bit. The clear and the set then compete for the same flops. The bench provokes this by starting a one-shot conversion and timing a status read to the cycle in which conv_done is taken, while an older, different alarm bit is already pending. It judges the outcome by requiring that the old bit is gone and the new bit is present afterwards.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

    localparam int unsigned RES_W   = 8;
    localparam int unsigned N_CHAN  = 2;
    localparam int unsigned N_LIM   = 2 * N_CHAN;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_RATE = 3'd1,
        A_LHI  = 3'd2,
        A_LLO  = 3'd3,
        A_RHI  = 3'd4,
        A_RLO  = 3'd5,
        A_STAT = 3'd6,
        A_TRIG = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/conv_tick_timer.sv
module conv_tick_timer #(
    parameter int unsigned TICK_CYC = 8,
    parameter int unsigned RATE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              busy,
    input  logic [RATE_W-1:0] rate,
    output logic              fire
);
    localparam int unsigned MAX_SHIFT = (1 << RATE_W) - 1;
    localparam int unsigned CNT_W     = $clog2(TICK_CYC * (1 << MAX_SHIFT) + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] period;

    always_comb begin
        period = CNT_W'(TICK_CYC) << (RATE_W'(MAX_SHIFT) - rate);
        fire   = 1'b0;
        cnt_d  = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == '0) begin
            if (!busy) begin
                fire  = 1'b1;
                cnt_d = period - 1'b1;
            end
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R13
    idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> !fire);

endmodule

// File: rtl/conv_limit_cmp.sv
module conv_limit_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    output logic         over,
    output logic         under
);
    always_comb begin
        over  = $signed(value) > $signed(hi);
        under = $signed(value) < $signed(lo);
    end
endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int unsigned TICK_CYC = 8,
    parameter int unsigned RATE_W   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [7:0]   wr_data,
    input  logic         rd_en,
    input  logic [2:0]   rd_addr,
    output logic [7:0]   rd_data,
    output logic         conv_req,
    input  logic         conv_done,
    input  logic [7:0]   local_temp,
    input  logic [7:0]   remote_temp,
    output logic [3:0]   status,
    output logic         alert_n
);
    localparam logic [RATE_W-1:0] MAX_CODE = '1;

    typedef struct packed {
        logic                         mask;
        logic                         stby;
        logic [RATE_W-1:0]            rate;
        logic [N_LIM-1:0][RES_W-1:0]  lim;
        logic [N_LIM-1:0]             stat;
        logic                         busy;
        logic                         req;
    } st_t;

    st_t s_d, s_q;

    logic                         fire;
    logic                         trig;
    logic [N_LIM-1:0]             hit;
    logic [N_CHAN-1:0][RES_W-1:0] val;

    assign val[0] = local_temp;
    assign val[1] = remote_temp;

    conv_tick_timer #(.TICK_CYC(TICK_CYC), .RATE_W(RATE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!s_q.stby),
        .busy  (s_q.busy),
        .rate  (s_q.rate),
        .fire  (fire)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        conv_limit_cmp #(.W(RES_W)) u_cmp (
            .value (val[c]),
            .hi    (s_q.lim[2*c]),
            .lo    (s_q.lim[2*c+1]),
            .over  (hit[2*c]),
            .under (hit[2*c+1])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        trig    = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    s_d.mask = wr_data[7];
                    s_d.stby = wr_data[6];
                end
                A_RATE: s_d.rate = (wr_data > 8'(MAX_CODE)) ? MAX_CODE : wr_data[RATE_W-1:0];
                A_LHI:  s_d.lim[0] = wr_data;
                A_LLO:  s_d.lim[1] = wr_data;
                A_RHI:  s_d.lim[2] = wr_data;
                A_RLO:  s_d.lim[3] = wr_data;
                A_TRIG: trig = s_q.stby && !s_q.busy;
                default: ;
            endcase
        end
        if (rd_en && rd_addr == A_STAT) s_d.stat = '0;
        if (conv_done && s_q.busy) begin
            s_d.busy = 1'b0;
            s_d.stat = s_d.stat | hit;
        end
        if (fire || trig) begin
            s_d.req  = 1'b1;
            s_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.lim  <= {8'h80, 8'h7F, 8'h80, 8'h7F};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {s_q.mask, s_q.stby, 6'b0};
            A_RATE:  rd_data = {{(8-RATE_W){1'b0}}, s_q.rate};
            A_LHI:   rd_data = s_q.lim[0];
            A_LLO:   rd_data = s_q.lim[1];
            A_RHI:   rd_data = s_q.lim[2];
            A_RLO:   rd_data = s_q.lim[3];
            A_STAT:  rd_data = {4'b0, s_q.stat};
            default: rd_data = 8'h00;
        endcase
    end

    assign conv_req = s_q.req;
    assign status   = s_q.stat;
    assign alert_n  = ~((|s_q.stat) & ~s_q.mask);

    // R14
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R13
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stby && !(wr_en && wr_addr == A_TRIG)) |=> !conv_req);

    // R6
    local_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && s_q.busy && ($signed(local_temp) > $signed(s_q.lim[0]))) |=> status[0]);

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == A_STAT) |=> ((status & $past(status)) == $past(status)));

    // R4
    rate_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_RATE && wr_data > 8'd7) |=> (s_q.rate == MAX_CODE));

    // R10
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stby && !s_q.busy && wr_en && wr_addr == A_CTRL && !wr_data[6]) |=> ##1 conv_req);

endmodule

// File: tb/conv_sched_tb.sv
`timescale 1ns/1ps
module conv_sched_tb;
    localparam int unsigned TICK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       conv_req, conv_done;
    logic [7:0] loc_v = 8'h00, rem_v = 8'h00;
    logic [3:0] status;
    logic       alert_n;
    logic       done_q;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= conv_req;
    end
    assign conv_done = done_q;

    conv_sched #(.TICK_CYC(TICK)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .conv_req(conv_req),
        .conv_done(conv_done), .local_temp(loc_v), .remote_temp(rem_v),
        .status(status), .alert_n(alert_n)
    );

    // {local, remote, local hi, local lo, remote hi, remote lo, expected status}
    localparam logic [51:0] VEC [6] = '{
        {8'h51, 8'h14, 8'h50, 8'h00, 8'h64, 8'h00, 4'b0001},
        {8'h50, 8'h14, 8'h50, 8'h50, 8'h14, 8'h14, 4'b0000},
        {8'hF6, 8'h05, 8'h00, 8'hFB, 8'h10, 8'h00, 4'b0010},
        {8'h01, 8'h81, 8'h7F, 8'h80, 8'h7F, 8'h80, 4'b0000},
        {8'h7F, 8'h80, 8'h7E, 8'h00, 8'h00, 8'h81, 4'b1001},
        {8'h00, 8'h30, 8'hFF, 8'h01, 8'h2F, 8'h31, 4'b1111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(output int p);
        while (!conv_req) @(negedge clk);
        @(negedge clk);
        while (!conv_req) @(negedge clk);
        p = 0;
        do begin @(negedge clk); p++; end while (!conv_req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int p, cnt;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(6);

        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(3'd1, d); chk("R1 rate", d, 8'h00);
        rd(3'd6, d); chk("R1 status", d, 8'h00);
        chk("R1 alert_n", alert_n, 1'b1);
        rd(3'd2, d); chk("R5 local hi reset", d, 8'h7F);
        rd(3'd5, d); chk("R5 remote lo reset", d, 8'h80);

        // R4 clamp
        wr(3'd1, 8'h1F); rd(3'd1, d); chk("R4 clamp", d, 8'h07);

        // R3 periods
        measure(p); chk("R3 code7", p, TICK);
        wr(3'd1, 8'h05); measure(p); chk("R3 code5", p, TICK * 4);
        wr(3'd1, 8'h00); measure(p); chk("R3 code0", p, TICK * 128);

        // R9 trigger in run mode ignored
        wr(3'd1, 8'h05);
        measure(p);
        while (!conv_req) @(negedge clk);
        wr(3'd7, 8'h55);
        cnt = 1;
        while (!conv_req) begin @(negedge clk); cnt++; end
        chk("R9 trigger in run", cnt, TICK * 4);

        // R13 standby quiet, R2 layout
        wr(3'd0, 8'h40);
        wait_cyc(10);
        cnt = 0;
        for (int i = 0; i < 600; i++) begin @(negedge clk); if (conv_req) cnt++; end
        chk("R13 standby quiet", cnt, 0);
        wr(3'd0, 8'hFF); rd(3'd0, d); chk("R2 reserved zero", d, 8'hC0);
        wr(3'd0, 8'h40); rd(3'd0, d); chk("R2 standby readback", d, 8'h40);

        // R6 R7 R12 vector table
        for (int v = 0; v < 6; v++) begin
            wr(3'd2, VEC[v][35:28]); wr(3'd3, VEC[v][27:20]);
            wr(3'd4, VEC[v][19:12]); wr(3'd5, VEC[v][11:4]);
            loc_v = VEC[v][51:44]; rem_v = VEC[v][43:36];
            rd(3'd6, d);
            wr(3'd7, 8'hA5);
            wait_cyc(3);
            chk($sformatf("R6/R7 vector %0d status", v), status, VEC[v][3:0]);
            chk($sformatf("R12 vector %0d alert_n", v), alert_n, (VEC[v][3:0] == 4'b0));
            rd(3'd6, d);
        end
        rd(3'd4, d); chk("R5 remote hi readback", d, 8'h2F);

        // R8 single request, data not kept
        cnt = 0;
        wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'hAB;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        chk("R8 request next cycle", conv_req, 1'b1);
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (conv_req) cnt++; end
        chk("R8 exactly one", cnt, 0);
        rd(3'd7, d); chk("R8 trigger reads zero", d, 8'h00);

        // R12 mask
        wr(3'd2, 8'h50); wr(3'd3, 8'h00); wr(3'd4, 8'h64); wr(3'd5, 8'h00);
        loc_v = 8'h51; rem_v = 8'h14;
        rd(3'd6, d);
        wr(3'd7, 8'h00); wait_cyc(3);
        chk("R12 alarm low", alert_n, 1'b0);
        wr(3'd0, 8'hC0);
        chk("R12 masked alert_n", alert_n, 1'b1);
        chk("R12 masked status kept", status, 4'b0001);
        wr(3'd0, 8'h40);
        chk("R12 unmasked", alert_n, 1'b0);

        // R11 sticky
        loc_v = 8'h14;
        wr(3'd7, 8'h00); wait_cyc(3);
        chk("R11 sticky", status, 4'b0001);

        // R11 clear and set in the same cycle
        rem_v = 8'hF0;
        wr(3'd7, 8'h00);
        @(negedge clk);
        rd(3'd6, d);
        chk("R11 read returns old", d, 8'h01);
        chk("R11 set wins over clear", status, 4'b1000);
        rd(3'd6, d);
        chk("R11 cleared", status, 4'b0000);
        chk("R12 clear releases", alert_n, 1'b1);

        // R10 wake
        rem_v = 8'h14;
        wait_cyc(4);
        wr(3'd0, 8'h00);
        chk("R10 not yet", conv_req, 1'b0);
        @(negedge clk);
        chk("R10 immediate request", conv_req, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule